// File: doc/BRIEF.md
# Level-Sensitive Interrupt State Tracker

This block keeps the per-interrupt state that an interrupt controller needs for sources that signal by level rather than by edge. Each source has its own four-state machine with the states Inactive, Pending, Active and Active-and-Pending. The raw source level first passes through a two-flop synchroniser. A CPU acknowledge strobe collects the interrupt ID, and a deactivate strobe ends the service. A request line to the CPU is high only while the source is Pending. A pending bit can be polled, so software can confirm that the controller has seen the level drop before it deactivates.

The hazard the block models is deactivation while the source line is still high. When the level is still asserted, the deactivate returns the state to Pending rather than Inactive, and the CPU is signalled a second time. Several interrupt IDs share the module by replication. Source `i` answers with ID `BASE_ID + i`. Each source has its own strobes and outputs, and no arbitration takes place between sources.

Top module: `lvl_irq_tracker`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), every source is Inactive. `irq_o` and `pend_o` read 0, and every `ack_id_o` field reads the spurious ID 1023.
- R2: A rising source level in Inactive moves the source to Pending. `irq_o` and `pend_o` rise after the third clock edge that follows the level change (two synchroniser flops, then the state register). They are still 0 after the second edge.
- R3: An acknowledge in Pending loads `BASE_ID + i` into field `i` of `ack_id_o` (bits `i*ID_W` upward) on the same edge. The source moves to Active-and-Pending if the synchronised level is high (`pend_o`=1, `irq_o`=0), or to Active if it is low (`pend_o`=0, `irq_o`=0).
- R4: A deactivate in Active-and-Pending while the synchronised level is still high moves the source to Pending, and `irq_o` rises again on that edge.
- R5: In Active-and-Pending, a level drop moves the source to Active. `pend_o` keeps reading 1 for two edges after the drop and falls on the third. A deactivate from Active, or from Active-and-Pending with a low synchronised level, moves the source to Inactive.
- R6: An acknowledge while the source is not Pending returns the spurious ID 1023 and leaves `irq_o` and `pend_o` unchanged.
- R7: In Pending, a level drop with no acknowledge returns the source to Inactive three edges after the drop.
- R8: When a deactivate and a level change fall in the same cycle, the synchronised level sampled on that edge alone decides the next state.
- R9: A deactivate while Inactive or Pending has no effect.
- R10: Sources are independent. Activity on one source never changes the outputs of another, and each source returns its own ID.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_level_i | input | NUM_SRC | Raw asynchronous interrupt levels, one bit per source |
| ack_stb_i | input | NUM_SRC | Acknowledge strobe per source |
| deact_stb_i | input | NUM_SRC | Deactivate strobe per source |
| irq_o | output | NUM_SRC | CPU request, high only in Pending |
| pend_o | output | NUM_SRC | Pollable pending bit (Pending or Active-and-Pending) |
| ack_id_o | output | NUM_SRC*ID_W | ID returned by the most recent acknowledge of each source, one ID_W field per source |

## Verification
A wrong state shows up at `irq_o` and `pend_o` within one edge of the next strobe or synchronised level change. A source wrongly left Active instead of Inactive shows only when the level rises again: `irq_o` then stays low rather than rising three edges later, so the bench re-raises the level after each deactivate to tell the two apart. The synchroniser latency is checked on both sides of the third edge. The same-cycle race between a deactivate and a level drop is placed on each side of the synchronised change.

// File: rtl/lvl_irq_pkg.sv
// Package: shared state encoding and next-state function for the
// level-sensitive interrupt tracker. Assumes one synchronised level per source.
package lvl_irq_pkg;

    typedef enum logic [1:0] {
        ST_INACTIVE = 2'd0,
        ST_PENDING  = 2'd1,
        ST_ACTIVE   = 2'd2,
        ST_ACT_PEND = 2'd3
    } irq_state_e;

    // Next state from current state, synchronised level and the two strobes.
    function automatic irq_state_e irq_next_state(
        input irq_state_e cur,
        input logic       lvl,
        input logic       ack,
        input logic       deact
    );
        irq_state_e nxt;
        nxt = cur;
        case (cur)
            ST_INACTIVE: nxt = lvl ? ST_PENDING : ST_INACTIVE;
            ST_PENDING: begin
                if (ack)       nxt = lvl ? ST_ACT_PEND : ST_ACTIVE;
                else if (!lvl) nxt = ST_INACTIVE;
                else           nxt = ST_PENDING;
            end
            ST_ACTIVE, ST_ACT_PEND: begin
                if (deact) nxt = lvl ? ST_PENDING : ST_INACTIVE;
                else       nxt = lvl ? ST_ACT_PEND : ST_ACTIVE;
            end
            default: nxt = ST_INACTIVE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/lvl_sync.sv
// Module: multi-flop synchroniser for one asynchronous level.
// Assumes STAGES >= 2; output lags the input by STAGES clock edges.
module lvl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw level through the flop chain; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/lvl_irq_fsm.sv
// Module: state machine for one level-sensitive interrupt source.
// Assumes lvl_i is already synchronised; strobes are single-cycle.
module lvl_irq_fsm
    import lvl_irq_pkg::*;
#(
    parameter int              ID_W    = 10,
    parameter logic [ID_W-1:0] MY_ID   = '0,
    parameter logic [ID_W-1:0] SPUR_ID = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            lvl_i,
    input  logic            ack_i,
    input  logic            deact_i,
    output logic            irq_o,
    output logic            pend_o,
    output logic [ID_W-1:0] ack_id_o
);
    irq_state_e state_q;
    logic       is_pend;

    assign is_pend = (state_q == ST_PENDING);

    // Advance the interrupt state every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_INACTIVE;
        else        state_q <= irq_next_state(state_q, lvl_i, ack_i, deact_i);
    end

    // Latch the ID answered to the last acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)     ack_id_o <= SPUR_ID;
        else if (ack_i) ack_id_o <= is_pend ? MY_ID : SPUR_ID;
    end

    // Decode the CPU request and the pollable pending bit.
    always_comb begin
        irq_o  = (state_q == ST_PENDING);
        pend_o = (state_q == ST_PENDING) || (state_q == ST_ACT_PEND);
    end

    a_r2_idle_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_INACTIVE && lvl_i) |=> irq_o);

    a_r3_ack_serves: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && state_q == ST_PENDING) |=>
            (!irq_o && ack_id_o == MY_ID && pend_o == $past(lvl_i)));

    a_r4_redeliver: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_i && lvl_i && state_q == ST_ACT_PEND) |=> irq_o);

    a_r5_deact_low: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_i && !lvl_i && (state_q == ST_ACTIVE || state_q == ST_ACT_PEND))
            |=> (state_q == ST_INACTIVE));

    a_r6_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && state_q != ST_PENDING) |=> (ack_id_o == SPUR_ID));

    a_r9_irq_implies_pend: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> pend_o);

endmodule

// File: rtl/lvl_irq_tracker.sv
// Module: top of the level-sensitive interrupt tracker. Replicates one
// synchroniser and one state machine per source; source i answers BASE_ID+i.
// Assumes BASE_ID+NUM_SRC-1 fits in ID_W bits and differs from SPURIOUS_ID.
module lvl_irq_tracker #(
    parameter int NUM_SRC     = 2,
    parameter int ID_W        = 10,
    parameter int BASE_ID     = 27,
    parameter int SPURIOUS_ID = 1023,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_SRC-1:0]      src_level_i,
    input  logic [NUM_SRC-1:0]      ack_stb_i,
    input  logic [NUM_SRC-1:0]      deact_stb_i,
    output logic [NUM_SRC-1:0]      irq_o,
    output logic [NUM_SRC-1:0]      pend_o,
    output logic [NUM_SRC*ID_W-1:0] ack_id_o
);
    localparam logic [ID_W-1:0] SPUR_ID_L = ID_W'(SPURIOUS_ID);

    logic [NUM_SRC-1:0] lvl_sync_w;

    for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
        localparam logic [ID_W-1:0] SRC_ID = ID_W'(BASE_ID + gi);

        // Bring the raw level into the clock domain.
        lvl_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk   (clk),
            .rst_n (rst_n),
            .d_i   (src_level_i[gi]),
            .q_o   (lvl_sync_w[gi])
        );

        // Track the interrupt state of this source.
        lvl_irq_fsm #(.ID_W(ID_W), .MY_ID(SRC_ID), .SPUR_ID(SPUR_ID_L)) fsm_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .lvl_i    (lvl_sync_w[gi]),
            .ack_i    (ack_stb_i[gi]),
            .deact_i  (deact_stb_i[gi]),
            .irq_o    (irq_o[gi]),
            .pend_o   (pend_o[gi]),
            .ack_id_o (ack_id_o[gi*ID_W +: ID_W])
        );
    end

endmodule

// File: tb/lvl_irq_tracker_tb_top.sv
module lvl_irq_tracker_tb_top;
    localparam int N    = 2;
    localparam int IDW  = 10;
    localparam int BASE = 27;
    localparam int SPUR = 1023;

    logic           clk = 0;
    logic           rst_n = 0;
    logic [N-1:0]   src = '0, ack = '0, deact = '0;
    logic [N-1:0]   irq, pend;
    logic [N*IDW-1:0] ids;
    int n_chk = 0, n_bad = 0;

    always #5 clk = ~clk;

    lvl_irq_tracker #(.NUM_SRC(N), .ID_W(IDW), .BASE_ID(BASE),
                      .SPURIOUS_ID(SPUR), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_level_i(src), .ack_stb_i(ack),
        .deact_stb_i(deact), .irq_o(irq), .pend_o(pend), .ack_id_o(ids));

    task automatic tick(int n = 1);
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(string tag, int got, int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
        end
    endtask

    function automatic int idf(int i);
        return int'(ids[i*IDW +: IDW]);
    endfunction

    task automatic pulse_ack(int i);
        ack[i] = 1'b1; tick(); ack[i] = 1'b0;
    endtask

    task automatic pulse_deact(int i);
        deact[i] = 1'b1; tick(); deact[i] = 1'b0;
    endtask

    task automatic t_reset;
        tick(3); rst_n = 1'b1; tick();
        chk("R1 irq", int'(irq), 0);
        chk("R1 pend", int'(pend), 0);
        chk("R1 id0", idf(0), SPUR);
        chk("R1 id1", idf(1), SPUR);
    endtask

    task automatic t_rise;
        src[0] = 1'b1; tick(2);
        chk("R2 latency irq0", int'(irq[0]), 0);
        tick();
        chk("R2 irq0", int'(irq[0]), 1);
        chk("R2 pend0", int'(pend[0]), 1);
        chk("R10 irq1 quiet", int'(irq[1]), 0);
    endtask

    task automatic t_ack_high_and_redeliver;
        pulse_ack(0);
        chk("R3 id0", idf(0), BASE);
        chk("R3 irq0", int'(irq[0]), 0);
        chk("R3 pend0", int'(pend[0]), 1);
        pulse_ack(0);
        chk("R6 id0 spurious", idf(0), SPUR);
        chk("R6 pend0 kept", int'(pend[0]), 1);
        chk("R6 irq0 kept", int'(irq[0]), 0);
        pulse_deact(0);
        chk("R4 irq0 again", int'(irq[0]), 1);
        pulse_deact(0);
        chk("R9 irq0 in pending", int'(irq[0]), 1);
        chk("R9 pend0 in pending", int'(pend[0]), 1);
        pulse_ack(0);
        chk("R3 id0 second", idf(0), BASE);
    endtask

    task automatic t_drop_then_deact;
        src[0] = 1'b0; tick(2);
        chk("R5 pend0 still seen", int'(pend[0]), 1);
        tick();
        chk("R5 pend0 cleared", int'(pend[0]), 0);
        chk("R5 irq0 low", int'(irq[0]), 0);
        pulse_deact(0);
        src[0] = 1'b1; tick(3);
        chk("R5 inactive after deact", int'(irq[0]), 1);
    endtask

    task automatic t_pending_drop;
        src[0] = 1'b0; tick(3);
        chk("R7 irq0", int'(irq[0]), 0);
        chk("R7 pend0", int'(pend[0]), 0);
        pulse_ack(0);
        chk("R6 id0 inactive", idf(0), SPUR);
        chk("R6 irq0 inactive", int'(irq[0]), 0);
        pulse_deact(0);
        chk("R9 pend0 inactive", int'(pend[0]), 0);
    endtask

    task automatic t_race;
        src[0] = 1'b1; tick(3); pulse_ack(0);
        src[0] = 1'b0; deact[0] = 1'b1; tick(); deact[0] = 1'b0;
        chk("R8 sync high wins", int'(irq[0]), 1);
        tick(2);
        chk("R8 then idle irq0", int'(irq[0]), 0);
        chk("R8 then idle pend0", int'(pend[0]), 0);
        src[0] = 1'b1; tick(3); pulse_ack(0);
        src[0] = 1'b0; tick(2);
        pulse_deact(0);
        chk("R8 sync low irq0", int'(irq[0]), 0);
        chk("R8 sync low pend0", int'(pend[0]), 0);
        src[0] = 1'b1; tick(3);
        chk("R8 was inactive", int'(irq[0]), 1);
    endtask

    task automatic t_ack_low;
        src[0] = 1'b0; tick(2);
        pulse_ack(0);
        chk("R3 low id0", idf(0), BASE);
        chk("R3 low pend0", int'(pend[0]), 0);
        chk("R3 low irq0", int'(irq[0]), 0);
        src[0] = 1'b1; tick(3);
        chk("R3 active then level", int'(pend[0]), 1);
        chk("R3 active no irq", int'(irq[0]), 0);
        pulse_deact(0);
        chk("R4 irq0 re-signal", int'(irq[0]), 1);
    endtask

    task automatic t_indep;
        src[1] = 1'b1; tick(3);
        chk("R10 irq1", int'(irq[1]), 1);
        pulse_ack(1);
        chk("R10 id1", idf(1), BASE + 1);
        chk("R10 id0 kept", idf(0), BASE);
        chk("R10 irq0 kept", int'(irq[0]), 1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_rise();
        t_ack_high_and_redeliver();
        t_drop_then_deact();
        t_pending_drop();
        t_race();
        t_ack_low();
        t_indep();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired got=0 expected=1");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule